// File: doc/BRIEF.md
# Linked-List Cell Queue Manager

This block keeps several first-in first-out queues of buffer numbers without storing the buffers themselves. Each queue is described by a head register and a tail register. A single link map, indexed by buffer number, chains each queued buffer to the one behind it. Buffer number zero is reserved as the null value. A queue whose head is zero therefore holds no buffers at all, and no dummy element is needed.

A single requester issues one operation at a time: it appends a buffer to a chosen queue, or removes the buffer at the front of a chosen queue. Each accepted operation runs for a fixed two cycles. Completion is signalled by a one-cycle done pulse, which carries the removed buffer number, an empty indication or an error indication. While an operation is in flight, `req_ready` is low and any request offered is not taken.

Top module: `cellq_mgr`

## Requirements
- R1: A queue reports empty on removal exactly when it holds no buffers. The queue's head register is zero in that case, and only then.
- R2: Appending a buffer to an empty queue makes that buffer both the first and the last element of the queue. The next removal from that queue returns it.
- R3: Appending to a non-empty queue places the buffer behind the current last element. Removals from one queue return buffers in the order they were appended.
- R4: Removing from an empty queue changes no state. The completion reports `done_empty`=1 and `done_buf`=0.
- R5: Removing the only element of a queue returns it with `done_empty`=0 and leaves the queue empty.
- R6: Removing from a queue with two or more elements returns the front buffer. The following element becomes the new front.
- R7: The link map is never written with the value zero.
- R8: `req_ready` is high when idle. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is then low for one cycle. `done` is high for exactly the one cycle that follows the second rising edge after acceptance. A request offered while `req_ready` is low has no effect.
- R9: Appending buffer number zero completes with `done_err`=1, `done_buf`=0 and `done_empty`=0, and changes no queue.
- R10: An operation on one queue never changes the contents of any other queue.
- R11: After reset every queue is empty, `req_ready` is 1 and `done` is 0.
- R12: Encodings: `req_op`=0 appends, `req_op`=1 removes. `done_buf` is 0 for every completion except a successful removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 1 | 0 = append, 1 = remove |
| req_queue | input | QW | Target queue number |
| req_buf | input | BW | Buffer number to append (ignored on removal) |
| done | output | 1 | One-cycle completion pulse |
| done_buf | output | BW | Removed buffer number, else 0 |
| done_empty | output | 1 | Removal found the queue empty |
| done_err | output | 1 | Append of the reserved buffer number zero |

## Verification
The bench drives a queue to exactly one element and then removes it. A design that tested only the head for null, and never compared head with tail, would then hand back a stale link and never go empty. It removes from empty queues in order to catch a design that alters the head or returns garbage. It appends buffer zero to catch a design that links in the null value and corrupts a chain. It also offers requests while busy, to expose a design that accepts a second operation mid-flight and loses or duplicates a buffer. Long random mixes across all queues compare every removal against a reference model, so any cross-queue corruption of the shared link map shows up as a wrong buffer number.

// File: rtl/cellq_pkg.sv
package cellq_pkg;

    typedef enum logic {
        OP_APPEND = 1'b0,
        OP_REMOVE = 1'b1
    } cq_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } cq_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cq_link_ram.sv
module cq_link_ram #(
    parameter int NUM_BUFS = 32,
    parameter int BW       = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [BW-1:0] waddr,
    input  logic [BW-1:0] wdata,
    input  logic [BW-1:0] raddr,
    output logic [BW-1:0] rdata
);
    logic [BW-1:0] mem [NUM_BUFS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read is combinational so the controller resolves a removal in one cycle
    assign rdata = mem[raddr];
endmodule

// File: rtl/cq_ht_regs.sv
module cq_ht_regs #(
    parameter int NQ = 4,
    parameter int QW = 2,
    parameter int BW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [QW-1:0]    sel_q,
    output logic [BW-1:0]    head_rd,
    output logic [BW-1:0]    tail_rd,
    input  logic             we_head,
    input  logic             we_tail,
    input  logic [BW-1:0]    head_wdata,
    input  logic [BW-1:0]    tail_wdata,
    output logic [NQ*BW-1:0] head_flat
);
    logic [BW-1:0] head_r [NQ];
    logic [BW-1:0] tail_r [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        always_ff @(posedge clk) begin
            if (rst) begin
                head_r[g] <= '0;
                tail_r[g] <= '0;
            end else begin
                if (we_head && sel_q == QW'(g)) head_r[g] <= head_wdata;
                if (we_tail && sel_q == QW'(g)) tail_r[g] <= tail_wdata;
            end
        end
        assign head_flat[g*BW +: BW] = head_r[g];
    end

    assign head_rd = head_r[sel_q];
    assign tail_rd = tail_r[sel_q];
endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl
    import cellq_pkg::*;
#(
    parameter int QW = 2,
    parameter int BW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_op,
    input  logic [QW-1:0] req_queue,
    input  logic [BW-1:0] req_buf,
    output logic [QW-1:0] sel_q,
    input  logic [BW-1:0] head_rd,
    input  logic [BW-1:0] tail_rd,
    input  logic [BW-1:0] link_rd,
    output logic [BW-1:0] link_raddr,
    output logic          we_head,
    output logic          we_tail,
    output logic [BW-1:0] head_wdata,
    output logic [BW-1:0] tail_wdata,
    output logic          link_we,
    output logic [BW-1:0] link_waddr,
    output logic [BW-1:0] link_wdata,
    output logic          done,
    output logic [BW-1:0] done_buf,
    output logic          done_empty,
    output logic          done_err
);
    typedef struct packed {
        cq_op_e        op;
        logic [QW-1:0] queue;
        logic [BW-1:0] buf_no;
    } cq_req_t;

    typedef struct packed {
        logic          empty;
        logic          err;
        logic [BW-1:0] buf_no;
    } cq_res_t;

    cq_state_e state_q;
    cq_req_t   req_q;
    cq_res_t   res_c;
    logic      q_empty;

    assign req_ready  = (state_q == ST_IDLE);
    assign sel_q      = req_q.queue;
    assign link_raddr = head_rd;
    assign q_empty    = (head_rd == '0);

    always_comb begin
        we_head    = 1'b0;
        we_tail    = 1'b0;
        head_wdata = '0;
        tail_wdata = '0;
        link_we    = 1'b0;
        link_waddr = tail_rd;
        link_wdata = req_q.buf_no;
        res_c      = '0;
        if (state_q == ST_EXEC) begin
            if (req_q.op == OP_APPEND) begin
                if (req_q.buf_no == '0) begin
                    res_c.err = 1'b1;
                end else if (q_empty) begin
                    we_head    = 1'b1;
                    we_tail    = 1'b1;
                    head_wdata = req_q.buf_no;
                    tail_wdata = req_q.buf_no;
                end else begin
                    link_we    = 1'b1;
                    we_tail    = 1'b1;
                    tail_wdata = req_q.buf_no;
                end
            end else begin
                if (q_empty) begin
                    res_c.empty = 1'b1;
                end else begin
                    res_c.buf_no = head_rd;
                    we_head      = 1'b1;
                    head_wdata   = (head_rd == tail_rd) ? '0 : link_rd;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            req_q      <= '0;
            done       <= 1'b0;
            done_buf   <= '0;
            done_empty <= 1'b0;
            done_err   <= 1'b0;
        end else begin
            done       <= 1'b0;
            done_buf   <= '0;
            done_empty <= 1'b0;
            done_err   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q.op     <= cq_op_e'(req_op);
                        req_q.queue  <= req_queue;
                        req_q.buf_no <= req_buf;
                        state_q      <= ST_EXEC;
                    end
                end
                default: begin
                    done       <= 1'b1;
                    done_buf   <= res_c.buf_no;
                    done_empty <= res_c.empty;
                    done_err   <= res_c.err;
                    state_q    <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/cellq_mgr.sv
module cellq_mgr
    import cellq_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    parameter int NUM_BUFS   = 32,
    localparam int QW = idx_width(NUM_QUEUES),
    localparam int BW = idx_width(NUM_BUFS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_op,
    input  logic [QW-1:0] req_queue,
    input  logic [BW-1:0] req_buf,
    output logic          done,
    output logic [BW-1:0] done_buf,
    output logic          done_empty,
    output logic          done_err
);
    logic [QW-1:0]            sel_q;
    logic [BW-1:0]            head_rd, tail_rd, link_rd, link_raddr;
    logic                     we_head, we_tail, link_we;
    logic [BW-1:0]            head_wdata, tail_wdata, link_waddr, link_wdata;
    logic [NUM_QUEUES*BW-1:0] head_flat;

    cq_ctrl #(.QW(QW), .BW(BW)) ctrl_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_queue(req_queue), .req_buf(req_buf),
        .sel_q(sel_q), .head_rd(head_rd), .tail_rd(tail_rd),
        .link_rd(link_rd), .link_raddr(link_raddr),
        .we_head(we_head), .we_tail(we_tail),
        .head_wdata(head_wdata), .tail_wdata(tail_wdata),
        .link_we(link_we), .link_waddr(link_waddr), .link_wdata(link_wdata),
        .done(done), .done_buf(done_buf),
        .done_empty(done_empty), .done_err(done_err)
    );

    cq_ht_regs #(.NQ(NUM_QUEUES), .QW(QW), .BW(BW)) ht_i (
        .clk(clk), .rst(rst), .sel_q(sel_q),
        .head_rd(head_rd), .tail_rd(tail_rd),
        .we_head(we_head), .we_tail(we_tail),
        .head_wdata(head_wdata), .tail_wdata(tail_wdata),
        .head_flat(head_flat)
    );

    cq_link_ram #(.NUM_BUFS(NUM_BUFS), .BW(BW)) link_i (
        .clk(clk), .we(link_we), .waddr(link_waddr), .wdata(link_wdata),
        .raddr(link_raddr), .rdata(link_rd)
    );
endmodule

// File: rtl/cellq_mgr_chk.sv
module cellq_mgr_chk #(
    parameter int NQ = 4,
    parameter int QW = 2,
    parameter int BW = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_op,
    input logic [QW-1:0]    req_queue,
    input logic [BW-1:0]    req_buf,
    input logic             done,
    input logic [BW-1:0]    done_buf,
    input logic             done_empty,
    input logic             done_err,
    input logic             link_we,
    input logic [BW-1:0]    link_wdata,
    input logic [NQ*BW-1:0] head_flat
);
    logic          accept;
    logic [BW-1:0] cur_head;

    assign accept   = req_valid && req_ready;
    assign cur_head = head_flat[req_queue*BW +: BW];

    p_link_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_wdata != '0));

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!req_ready && !done));

    p_done_timing_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##1 (done && req_ready));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_zero_append_err_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_op && req_buf == '0) |=> ##1 (done_err && done_buf == '0));

    p_empty_remove_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && req_op && cur_head == '0) |=> ##1 (done_empty && done_buf == '0));

    p_nonempty_remove_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && req_op && cur_head != '0) |=> ##1 (!done_empty && done_buf != '0));
endmodule

bind cellq_mgr cellq_mgr_chk #(.NQ(NUM_QUEUES), .QW(QW), .BW(BW)) chk_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_queue(req_queue), .req_buf(req_buf),
    .done(done), .done_buf(done_buf),
    .done_empty(done_empty), .done_err(done_err),
    .link_we(link_we), .link_wdata(link_wdata), .head_flat(head_flat)
);

// File: tb/cellq_mgr_tb_top.sv
module cellq_mgr_tb_top;
    localparam int NQ = 4;
    localparam int NB = 32;
    localparam int QW = 2;
    localparam int BW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_op = 1'b0;
    logic [QW-1:0] req_queue = '0;
    logic [BW-1:0] req_buf = '0;
    logic          done;
    logic [BW-1:0] done_buf;
    logic          done_empty;
    logic          done_err;

    int checks = 0;
    int errors = 0;
    int mq [NQ][$];
    bit inuse [NB];

    always #10 clk = ~clk;

    cellq_mgr #(.NUM_QUEUES(NQ), .NUM_BUFS(NB)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_queue(req_queue), .req_buf(req_buf),
        .done(done), .done_buf(done_buf),
        .done_empty(done_empty), .done_err(done_err)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    // Expected result of an operation against the reference model
    function automatic void expect_op(input bit op, input int q, input int b,
                                      output int eb, output bit ee, output bit er,
                                      output string tag);
        eb = 0; ee = 0; er = 0;
        if (!op) begin
            if (b == 0) begin er = 1; tag = "R9 R12"; end
            else begin
                tag = (mq[q].size() == 0) ? "R2 R12" : "R3 R12";
                mq[q].push_back(b);
                inuse[b] = 1;
            end
        end else begin
            if (mq[q].size() == 0) begin ee = 1; tag = "R4 R1"; end
            else begin
                tag = (mq[q].size() == 1) ? "R5 R2" : "R6 R3 R7 R10";
                eb = mq[q].pop_front();
                inuse[eb] = 0;
            end
        end
    endfunction

    // Called at a negedge with the block idle; returns at the completion negedge
    task automatic do_op(input bit op, input int q, input int b, input bit poke);
        int eb; bit ee, er; string tag;
        expect_op(op, q, b, eb, ee, er, tag);
        req_valid = 1; req_op = op; req_queue = QW'(q); req_buf = BW'(b);
        @(posedge clk);
        @(negedge clk);
        check(!req_ready && !done, "R8",
              $sformatf("busy: ready=%0b done=%0b exp 0 0", req_ready, done));
        if (poke) begin
            // R8: request offered while busy must be ignored
            req_op = 1; req_queue = QW'((q + 1) % NQ);
        end else req_valid = 0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        check(done && req_ready, "R8",
              $sformatf("completion: done=%0b ready=%0b exp 1 1", done, req_ready));
        check(done_buf == BW'(eb) && done_empty == ee && done_err == er, tag,
              $sformatf("q=%0d op=%0b buf=%0d empty=%0b err=%0b exp buf=%0d empty=%0b err=%0b",
                        q, op, done_buf, done_empty, done_err, eb, ee, er));
    endtask

    function automatic int free_buf();
        for (int t = 0; t < 64; t++) begin
            int c = 1 + ($urandom % (NB - 1));
            if (!inuse[c]) return c;
        end
        for (int c = 1; c < NB; c++) if (!inuse[c]) return c;
        return -1;
    endfunction

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check(req_ready && !done, "R11",
              $sformatf("reset: ready=%0b done=%0b exp 1 0", req_ready, done));
        // R11 R1: every queue empty after reset
        for (int q = 0; q < NQ; q++) do_op(1, q, 0, 0);
        // R2 R5: single element in and out, then empty
        do_op(0, 0, 5, 0);
        do_op(1, 0, 0, 0);
        do_op(1, 0, 0, 0);
        // R9: buffer zero on empty and on non-empty queue
        do_op(0, 1, 0, 0);
        do_op(1, 1, 0, 0);
        do_op(0, 1, 7, 0);
        do_op(0, 1, 0, 0);
        do_op(0, 1, 9, 0);
        // R3 R6 R10: interleave queues
        do_op(0, 2, 3, 0);
        do_op(0, 1, 11, 0);
        do_op(0, 2, 4, 0);
        // R8: offered request while busy must not remove anything
        do_op(1, 1, 0, 1);
        do_op(1, 1, 0, 1);
        do_op(1, 2, 0, 0);
        do_op(1, 2, 0, 0);
        do_op(1, 1, 0, 0);
        do_op(1, 1, 0, 0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int q = $urandom % NQ;
            int r = $urandom % 100;
            if (r < 5) do_op(0, q, 0, 0);
            else if (r < 55) begin
                int b = free_buf();
                if (b < 0) do_op(1, q, 0, 0);
                else do_op(0, q, b, (r % 7) == 0);
            end else do_op(1, q, 0, (r % 5) == 0);
        end
        // Drain everything
        for (int q = 0; q < NQ; q++)
            while (mq[q].size() > 0) do_op(1, q, 0, 0);
        for (int q = 0; q < NQ; q++) do_op(1, q, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule